// File: doc/BRIEF.md
# GPIO Function Select and Output Latch Bank

This block is the register core of a general-purpose I/O controller for 54 pins. Each pin is given a 3-bit function code. The code selects plain input, driven output, or one of six alternate functions. Ten of these codes are packed into each 32-bit function word. The code of every pin is also presented on a flat select vector, so that pad muxing outside the block can route alternate functions.

Output levels are held in one latch per pin. Software changes a latch only through two write-one registers: one sets bits and the other clears them. Two agents can therefore change different pins without a read-modify-write race.

Pin inputs are resynchronised into the core clock domain. They can be read as a level word per 32-pin bank. The register bus is a plain single-cycle interface with byte addresses, a write strobe, and combinational read data.

Top module: `gpio_fsel_bank`

## Requirements
- R1: While reset is low, and right after it, every function code is 3'b000 (input), every output-enable is 0, every output latch is 0, and every function word reads 0.
- R2: Function words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. Pin p uses word p/10, bits (p%10)*3 up to (p%10)*3+2. Bits 30 and 31 of each word, and the slots of pins 54 to 59 in word 0x14, read back 0 and cannot be written.
- R3: The output-enable of a pin is 1 exactly when its function code is 3'b001.
- R4: A write to 0x1C (pins 0-31) or 0x20 (pins 32-53, at bit p-32) sets the output latch of every pin whose data bit is 1. Bits written as 0, and bits above pin 53, leave the latches unchanged.
- R5: A write to 0x28 (pins 0-31) or 0x2C (pins 32-53) clears the output latch of every pin whose data bit is 1. Bits written as 0 leave the latches unchanged.
- R6: The set and clear registers always read 0.
- R7: The pin output always shows the pin's latch. The latch keeps its value when the pin leaves output mode, and it can be set or cleared while the pin is not an output.
- R8: The level words at 0x34 (pins 0-31) and 0x38 (pins 32-53 in bits 0-21, upper bits 0) show the pin inputs after a two-flop synchronizer. A change becomes visible after the second rising clock edge, not the first. Writes to these words have no effect.
- R9: The function codes are: 000 input, 001 output, 100 alternate 0, 101 alternate 1, 110 alternate 2, 111 alternate 3, 011 alternate 4, 010 alternate 5. Pin p's stored code is presented on select-vector bits 3p to 3p+2.
- R10: Addresses that are not word-aligned, and aligned addresses outside the words above, read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 54 | Sampled pad levels, asynchronous |
| pin_oe | output | 54 | Per-pin output enable |
| pin_out | output | 54 | Per-pin output latch value |
| pin_func | output | 162 | Per-pin function code, 3 bits per pin |

## Verification
A table of function-word writes covers several patterns. All-ones words show the masking of the unused bits 30-31 and of the missing pin slots in the last word. An all-output word shows the enable decode on every pin of a word. A word with one low field shows the bit position of pin 0 within its word, and a mixed word exposes swapped or misplaced fields. Each of the eight codes is then written to one pin, which separates the output code from the six alternates and from input. The set and clear tests include zero writes and bits above the last pin, so they tell a write-one register apart from a plain data register. The level test samples one cycle and two cycles after a change, which catches a missing or extra synchronizer stage.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

   localparam int FN_W = 3;

   typedef enum logic [FN_W-1:0] {
      FN_IN   = 3'b000,
      FN_OUT  = 3'b001,
      FN_ALT5 = 3'b010,
      FN_ALT4 = 3'b011,
      FN_ALT0 = 3'b100,
      FN_ALT1 = 3'b101,
      FN_ALT2 = 3'b110,
      FN_ALT3 = 3'b111
   } gpio_fn_e;

   // Register window base positions, in 32-bit word units
   localparam int SET_WORD = 7;   // byte 0x1C
   localparam int CLR_WORD = 10;  // byte 0x28
   localparam int LVL_WORD = 13;  // byte 0x34

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 54,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= '0;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [WIDTH-1:0] r_chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) r_chain[i] <= '0;
         end else begin
            r_chain[0] <= d;
            for (int i = 1; i < STAGES; i++) r_chain[i] <= r_chain[i-1];
         end
      end
      assign q = r_chain[STAGES-1];
   end

endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS = 54,
   parameter int PER_WORD = 10,
   localparam int FW_BITS    = PER_WORD * FN_W,
   localparam int FSEL_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD,
   localparam int FIDX_W     = (FSEL_WORDS > 1) ? $clog2(FSEL_WORDS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [FIDX_W-1:0]        wr_idx,
   input  logic [FW_BITS-1:0]       wr_data,
   input  logic [FIDX_W-1:0]        rd_idx,
   output logic [FW_BITS-1:0]       rd_data,
   output logic [NUM_PINS*FN_W-1:0] func_o,
   output logic [NUM_PINS-1:0]      oe_o
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int WORD = p / PER_WORD;
      localparam int SLOT = (p % PER_WORD) * FN_W;
      logic [FN_W-1:0] r_fld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_fld <= FN_IN;
         else if (wr_en && (wr_idx == FIDX_W'(WORD)))
            r_fld <= wr_data[SLOT +: FN_W];
      end

      assign func_o[p*FN_W +: FN_W] = r_fld;
      assign oe_o[p]                = (r_fld == FN_OUT);
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < PER_WORD; s++) begin
         if (int'(rd_idx) * PER_WORD + s < NUM_PINS)
            rd_data[s*FN_W +: FN_W] = func_o[(int'(rd_idx) * PER_WORD + s) * FN_W +: FN_W];
      end
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32,
   localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [BANK_W-1:0]   bank,
   input  logic [DATA_W-1:0]   mask,
   output logic [NUM_PINS-1:0] q
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int BNK = p / DATA_W;
      localparam int BIT = p % DATA_W;
      logic hit;
      logic r_lat;

      assign hit = (bank == BANK_W'(BNK)) && mask[BIT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                r_lat <= 1'b0;
         else if (set_en && hit)    r_lat <= 1'b1;
         else if (clr_en && hit)    r_lat <= 1'b0;
      end

      assign q[p] = r_lat;
   end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS    = 54,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int PER_WORD    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_PINS-1:0]      pin_in,
   output logic [NUM_PINS-1:0]      pin_oe,
   output logic [NUM_PINS-1:0]      pin_out,
   output logic [NUM_PINS*FN_W-1:0] pin_func
);

   localparam int NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int FW_BITS    = PER_WORD * FN_W;
   localparam int FSEL_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
   localparam int FIDX_W     = (FSEL_WORDS > 1) ? $clog2(FSEL_WORDS) : 1;
   localparam int WIDX_W     = ADDR_W - 2;

   localparam logic [WIDX_W-1:0] W_FSEL_END = WIDX_W'(FSEL_WORDS);
   localparam logic [WIDX_W-1:0] W_SET      = WIDX_W'(SET_WORD);
   localparam logic [WIDX_W-1:0] W_SET_END  = WIDX_W'(SET_WORD + NUM_BANKS);
   localparam logic [WIDX_W-1:0] W_CLR      = WIDX_W'(CLR_WORD);
   localparam logic [WIDX_W-1:0] W_CLR_END  = WIDX_W'(CLR_WORD + NUM_BANKS);
   localparam logic [WIDX_W-1:0] W_LVL      = WIDX_W'(LVL_WORD);
   localparam logic [WIDX_W-1:0] W_LVL_END  = WIDX_W'(LVL_WORD + NUM_BANKS);

   // Elaboration-time parameter checks
   if (FW_BITS > DATA_W) begin : g_bad_pack
      $error("gpio_fsel_bank: PER_WORD fields do not fit in a data word");
   end
   if (FSEL_WORDS > SET_WORD || NUM_BANKS > CLR_WORD - SET_WORD ||
       NUM_BANKS > LVL_WORD - CLR_WORD) begin : g_bad_map
      $error("gpio_fsel_bank: register windows overlap for this pin count");
   end
   if ((LVL_WORD + NUM_BANKS) > (1 << WIDX_W)) begin : g_bad_addr
      $error("gpio_fsel_bank: ADDR_W too small for the register map");
   end

   // Address decode
   logic              aligned;
   logic [WIDX_W-1:0] word;
   logic              fsel_hit, set_hit, clr_hit, lvl_hit;
   logic [BANK_W-1:0] set_bank, clr_bank, lvl_bank;
   logic [FIDX_W-1:0] fsel_idx;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign word     = bus_addr[ADDR_W-1:2];
   assign fsel_hit = aligned && (word < W_FSEL_END);
   assign set_hit  = aligned && (word >= W_SET) && (word < W_SET_END);
   assign clr_hit  = aligned && (word >= W_CLR) && (word < W_CLR_END);
   assign lvl_hit  = aligned && (word >= W_LVL) && (word < W_LVL_END);
   assign fsel_idx = FIDX_W'(word);

   logic [WIDX_W-1:0] set_off, clr_off, lvl_off;
   assign set_off  = word - W_SET;
   assign clr_off  = word - W_CLR;
   assign lvl_off  = word - W_LVL;
   assign set_bank = BANK_W'(set_off);
   assign clr_bank = BANK_W'(clr_off);
   assign lvl_bank = BANK_W'(lvl_off);

   // Function-select storage
   logic [FW_BITS-1:0] fsel_rd;

   gpio_fsel_regs #(
      .NUM_PINS (NUM_PINS),
      .PER_WORD (PER_WORD)
   ) u_fsel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && fsel_hit),
      .wr_idx  (fsel_idx),
      .wr_data (bus_wdata[FW_BITS-1:0]),
      .rd_idx  (fsel_idx),
      .rd_data (fsel_rd),
      .func_o  (pin_func),
      .oe_o    (pin_oe)
   );

   // Output latches, written only through set and clear windows
   logic [BANK_W-1:0] lat_bank;
   assign lat_bank = set_hit ? set_bank : clr_bank;

   gpio_out_latch #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr && set_hit),
      .clr_en (bus_wr && clr_hit),
      .bank   (lat_bank),
      .mask   (bus_wdata),
      .q      (pin_out)
   );

   // Input synchronizer and level view
   logic [NUM_PINS-1:0] pin_sync;

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   logic [NUM_BANKS*DATA_W-1:0] lvl_pad;
   always_comb begin
      lvl_pad                 = '0;
      lvl_pad[NUM_PINS-1:0]   = pin_sync;
   end

   // Read mux; set and clear windows read as zero
   always_comb begin
      bus_rdata = '0;
      if (fsel_hit)
         bus_rdata[FW_BITS-1:0] = fsel_rd;
      else if (lvl_hit)
         bus_rdata = lvl_pad[lvl_bank*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/gpio_fsel_bank_chk.sv
module gpio_fsel_bank_chk
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int PER_WORD = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic                     bus_wr,
   input logic [DATA_W-1:0]        bus_rdata,
   input logic [NUM_PINS-1:0]      pin_oe,
   input logic [NUM_PINS-1:0]      pin_out,
   input logic [NUM_PINS*FN_W-1:0] pin_func
);

   localparam int NB  = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int NFW = (NUM_PINS + PER_WORD - 1) / PER_WORD;

   int  w;
   logic al, c_fsel, c_set, c_clr;
   assign w      = int'(bus_addr) / 4;
   assign al     = (bus_addr[1:0] == 2'b00);
   assign c_fsel = al && (w < NFW);
   assign c_set  = al && (w >= SET_WORD) && (w < SET_WORD + NB);
   assign c_clr  = al && (w >= CLR_WORD) && (w < CLR_WORD + NB);

   // R1: reset leaves every output at its idle value
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0 && pin_func == '0));

   // R2: function codes only move on a write into a function word
   p_func_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr && c_fsel) |-> $stable(pin_func));

   // R3: an enable only turns on after a function-word write
   p_oe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pin_oe & ~$past(pin_oe))) |-> $past(bus_wr && c_fsel));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      p_oe_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pin_oe[p] |-> (pin_func[p*FN_W +: FN_W] == FN_OUT));
   end

   // R4: a latch rises only after a set-window write
   p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pin_out & ~$past(pin_out))) |-> $past(bus_wr && c_set));

   // R5: a latch falls only after a clear-window write
   p_clr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~pin_out & $past(pin_out))) |-> $past(bus_wr && c_clr));

   // R6: set and clear windows read as zero
   p_setclr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_set || c_clr) |-> (bus_rdata == '0));

endmodule

bind gpio_fsel_bank gpio_fsel_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .PER_WORD (PER_WORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .pin_func  (pin_func)
);

// File: tb/gpio_fsel_bank_bench.sv
module gpio_fsel_bank_bench;

   localparam int NP = 54;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NP-1:0]  pin_in = '0;
   logic [NP-1:0]  pin_oe;
   logic [NP-1:0]  pin_out;
   logic [NP*3-1:0] pin_func;

   always #5 clk = ~clk;

   gpio_fsel_bank u_gpio_fsel_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out),
      .pin_func  (pin_func)
   );

   int checks = 0;
   int errors = 0;

   logic [2:0]    mf [NP];
   logic [NP-1:0] mout = '0;

   typedef struct packed {
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{8'h00, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
      '{8'h04, 32'h0924_9249, 32'h0924_9249},
      '{8'h08, 32'hC000_0001, 32'h0000_0001},
      '{8'h14, 32'hFFFF_FFFF, 32'h0000_0FFF},
      '{8'h10, 32'h1234_5678, 32'h1234_5678},
      '{8'h0C, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic chk(input string req, input string what,
                      input logic [191:0] act, input logic [191:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic fsel_model(input logic [7:0] a, input logic [31:0] d);
      for (int k = 0; k < 10; k++) begin
         if (int'(a) / 4 * 10 + k < NP) mf[int'(a) / 4 * 10 + k] = d[k*3 +: 3];
      end
   endtask

   function automatic logic [NP*3-1:0] model_func();
      logic [NP*3-1:0] f;
      for (int p = 0; p < NP; p++) f[p*3 +: 3] = mf[p];
      return f;
   endfunction

   task automatic check_fields(input string what);
      logic [NP-1:0] eo;
      for (int p = 0; p < NP; p++) eo[p] = (mf[p] == 3'b001);
      chk("R9", what, pin_func, model_func());
      chk("R3", what, pin_oe, eo);
   endtask

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [NP-1:0] pat;
      for (int p = 0; p < NP; p++) mf[p] = 3'b000;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "oe in reset", pin_oe, '0);
      chk("R1", "out in reset", pin_out, '0);
      chk("R1", "func in reset", pin_func, '0);
      rd(8'h00, r);
      chk("R1", "word0 in reset", r, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "out after reset", pin_out, '0);

      // R2 / R3 / R9: vector table of function-word writes
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i].addr, VEC[i].wdata);
         fsel_model(VEC[i].addr, VEC[i].wdata);
         rd(VEC[i].addr, r);
         chk("R2", $sformatf("readback vec %0d", i), r, VEC[i].exp);
         check_fields($sformatf("vec %0d", i));
      end

      // R9: every code on pin 3
      for (int c = 0; c < 8; c++) begin
         wr(8'h00, 32'(c) << 9);
         fsel_model(8'h00, 32'(c) << 9);
         check_fields($sformatf("code %0d on pin 3", c));
      end
      wr(8'h00, 32'h0);
      fsel_model(8'h00, 32'h0);

      // R4: set windows
      wr(8'h1C, 32'h8000_0001);
      mout[0] = 1'b1; mout[31] = 1'b1;
      chk("R4", "set bank0", pin_out, mout);
      wr(8'h20, 32'hFFFF_FFFF);
      mout[53:32] = '1;
      chk("R4", "set bank1 all ones", pin_out, mout);
      wr(8'h1C, 32'h0);
      chk("R4", "set with zero", pin_out, mout);

      // R6: set and clear read as zero
      rd(8'h1C, r); chk("R6", "read set0", r, 32'h0);
      rd(8'h20, r); chk("R6", "read set1", r, 32'h0);
      rd(8'h28, r); chk("R6", "read clr0", r, 32'h0);
      rd(8'h2C, r); chk("R6", "read clr1", r, 32'h0);

      // R5: clear windows
      wr(8'h2C, 32'h1);
      mout[32] = 1'b0;
      chk("R5", "clear pin 32", pin_out, mout);
      wr(8'h28, 32'h0);
      chk("R5", "clear with zero", pin_out, mout);
      wr(8'h28, 32'h8000_0000);
      mout[31] = 1'b0;
      chk("R5", "clear pin 31", pin_out, mout);

      // R7: latch retention across function changes
      chk("R7", "latch while input", {pin_oe[0], pin_out[0]}, 2'b01);
      wr(8'h00, 32'h1);
      fsel_model(8'h00, 32'h1);
      chk("R7", "enter output", {pin_oe[0], pin_out[0]}, 2'b11);
      wr(8'h28, 32'h1);
      mout[0] = 1'b0;
      chk("R7", "clear while output", {pin_oe[0], pin_out[0]}, 2'b10);
      wr(8'h00, 32'h0);
      fsel_model(8'h00, 32'h0);
      wr(8'h1C, 32'h1);
      mout[0] = 1'b1;
      chk("R7", "set while input", {pin_oe[0], pin_out[0]}, 2'b01);
      wr(8'h00, 32'h1);
      fsel_model(8'h00, 32'h1);
      chk("R7", "re-enter output", {pin_oe[0], pin_out[0]}, 2'b11);
      chk("R7", "all latches", pin_out, mout);

      // R8: synchronized level read
      pat = 54'h15_A5A5_C3C3_0FF0;
      @(negedge clk);
      pin_in = pat;
      @(negedge clk);
      rd(8'h34, r);
      chk("R8", "level after one edge", r, 32'h0);
      @(negedge clk);
      rd(8'h34, r);
      chk("R8", "level bank0 after two edges", r, pat[31:0]);
      rd(8'h38, r);
      chk("R8", "level bank1 after two edges", r, {10'h0, pat[53:32]});
      wr(8'h34, 32'h0);
      rd(8'h34, r);
      chk("R8", "level after write", r, pat[31:0]);
      chk("R8", "latches after level write", pin_out, mout);

      // R10: unmapped and unaligned addresses
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, r);
      chk("R10", "read 0x18", r, 32'h0);
      chk("R10", "func after 0x18 write", pin_func, model_func());
      wr(8'h1D, 32'hFFFF_FFFF);
      chk("R10", "latches after unaligned write", pin_out, mout);
      wr(8'h02, 32'hFFFF_FFFF);
      chk("R10", "func after unaligned write", pin_func, model_func());
      rd(8'h3C, r);
      chk("R10", "read 0x3C", r, 32'h0);
      rd(8'h35, r);
      chk("R10", "read 0x35", r, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule